// File: doc/BRIEF.md
# Masked Dual Time-of-Day Alarm

This block watches a running calendar clock and raises a request when the time matches one of two programmable alarms. Each alarm is four byte-wide registers (seconds, minutes, hours, day of week). The top bit of each register is a "don't care" mask, and the lower seven bits hold the BCD value to compare. Masking fields from the day downward turns a weekly alarm into a daily, hourly, per-minute or per-second alarm. The comparison runs only on the one-second tick, and the tick must come after the clock counters have settled on the new second. A match sets a sticky request flag. Any read or write of that alarm's own registers clears the flag.

The two alarms signal in different ways. Alarm 0 drives an active-low level line that stays asserted while its flag and its enable are both set. Alarm 1 drives an active-high pulse of fixed length whenever its flag rises while its enable is on. The pulse length is counted in strobes of a slow (32.768 kHz) enable. The register port is a single strobe with an 8-bit address whose top bit selects write (1) or read (0). A combinational read-data output returns the addressed alarm register or the status byte.

Top module: `dual_tod_alarm`

## Requirements
- R1: After reset all eight alarm registers and both request flags are zero, `irq0_n` is 1 and `irq1` is 0.
- R2: With every mask bit (bit 7) clear, an alarm matches only when the low 7 bits of all four registers equal the current seconds, minutes, hours and day.
- R3: A register with bit 7 set takes no part in the match. Masking day gives a daily match, day+hours an hourly one, day+hours+minutes a per-minute one, and all four a match on every tick.
- R4: An access with address bit 7 = 1 writes and with bit 7 = 0 reads. Low address 07h..0Ah holds alarm 0's seconds, minutes, hours and day in that order, and 0Bh..0Eh does the same for alarm 1. Reads of 10h return the status byte: bit 0 = flag 0, bit 1 = flag 1, bits 7..2 = 0. Other reads return 0, and writes to 90h change nothing.
- R5: A read or write of any register of an alarm clears that alarm's flag in the next cycle and leaves the other flag alone. A clear in the same cycle as a matching tick wins.
- R6: A flag is set only by a matching `sec_tick`, becomes visible the cycle after the tick, and stays set until cleared by R5.
- R7: `irq0_n` is 0 exactly while flag 0 and `irq_en0` are both 1.
- R8: One cycle after flag 1 rises with `irq_en1` set, `irq1` goes high for PULSE_TICKS cycles in which `slow_tick` is 1. It stays high when `slow_tick` is idle. A match while flag 1 is already set starts no new pulse.
- R9: While `irq_en1` is 0, `irq1` is 0. Clearing the enable cancels a pulse in progress, and raising it again does not restart that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe per second, after the clock update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours register value |
| cur_day | input | 7 | Current day of week |
| acc_valid | input | 1 | Register access strobe |
| acc_addr | input | 8 | Access address; bit 7 = write |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed register |
| irq_en0 | input | 1 | Enable for alarm 0 line |
| irq_en1 | input | 1 | Enable for alarm 1 line |
| slow_tick | input | 1 | 32.768 kHz enable strobe for pulse timing |
| status | output | 8 | Status byte with both flags |
| irq0_n | output | 1 | Alarm 0 active-low level |
| irq1 | output | 1 | Alarm 1 active-high pulse |

## Verification
On every cycle the checker enforces these rules: the zero padding of the status byte, flags cleared after an access to their own alarm, flags that only rise after a tick, the two enable rules for `irq0_n` and `irq1`, and an upper bound on the alarm 1 pulse measured in slow strobes. The masking rules (R2, R3) can only be shown by the bench's table of mask patterns against times that differ in one chosen field. The exact pulse length, the readback map and the clear-wins-over-set ordering can also only be shown by directed scenarios.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
   localparam int NUM_FIELDS = 4;   // sec, min, hour, day
   localparam int NUM_ALARMS = 2;
   localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);
   typedef enum logic [FIELD_IDX_W-1:0] {
      FLD_SEC  = 2'd0,
      FLD_MIN  = 2'd1,
      FLD_HOUR = 2'd2,
      FLD_DAY  = 2'd3
   } field_e;
endpackage

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
   import tod_alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7,
   parameter int BASE   = 7
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                sec_tick,
   input  logic [NUM_FIELDS-1:0][DATA_W-2:0]   now_time,
   input  logic                                acc_valid,
   input  logic                                acc_write,
   input  logic [IDX_W-1:0]                    acc_index,
   input  logic [DATA_W-1:0]                   wr_data,
   output logic [DATA_W-1:0]                   rd_val,
   output logic                                flag
);
   localparam int MASK_BIT = DATA_W - 1;
   localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(BASE);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(BASE + NUM_FIELDS - 1);

   logic [NUM_FIELDS-1:0][DATA_W-1:0] regs;
   logic [NUM_FIELDS-1:0]             fld_ok;
   logic [IDX_W-1:0]                  rel_idx;
   logic [FIELD_IDX_W-1:0]            sel;
   logic                              hit;
   logic                              match;

   assign hit     = acc_valid && (acc_index >= FIRST_IDX) && (acc_index <= LAST_IDX);
   assign rel_idx = acc_index - FIRST_IDX;
   assign sel     = rel_idx[FIELD_IDX_W-1:0];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
      assign fld_ok[f] = regs[f][MASK_BIT] ||
                         (regs[f][MASK_BIT-1:0] == now_time[f]);
   end

   assign match = &fld_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (hit && acc_write) begin
         regs[sel] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b0;
      end else if (sec_tick && match) begin
         flag <= 1'b1;
      end
   end

   assign rd_val = (hit && !acc_write) ? regs[sel] : '0;
endmodule

// File: rtl/tod_irq_pulse.sv
module tod_irq_pulse #(
   parameter int PULSE_TICKS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic enable,
   input  logic slow_tick,
   output logic pulse
);
   localparam int CNT_W = $clog2(PULSE_TICKS + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

   logic [CNT_W-1:0] remain;
   logic             flag_prev;
   logic             start;

   assign start = flag && !flag_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_prev <= 1'b0;
      end else begin
         flag_prev <= flag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (!enable) begin
         remain <= '0;
      end else if (start) begin
         remain <= LOAD_VAL;
      end else if (slow_tick && (remain != '0)) begin
         remain <= remain - 1'b1;
      end
   end

   assign pulse = enable && (remain != '0);
endmodule

// File: rtl/dual_tod_alarm.sv
module dual_tod_alarm
   import tod_alarm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int ALM_BASE    = 7,
   parameter int STATUS_IDX  = 16,
   parameter int PULSE_TICKS = 2048,
   parameter bit IRQ1_PULSE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [DATA_W-2:0] cur_sec,
   input  logic [DATA_W-2:0] cur_min,
   input  logic [DATA_W-2:0] cur_hour,
   input  logic [DATA_W-2:0] cur_day,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              irq_en0,
   input  logic              irq_en1,
   input  logic              slow_tick,
   output logic [DATA_W-1:0] status,
   output logic              irq0_n,
   output logic              irq1
);
   localparam int IDX_W = ADDR_W - 1;
   localparam logic [IDX_W-1:0] STATUS_V = IDX_W'(STATUS_IDX);

   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small");
   end
   if (ALM_BASE + NUM_ALARMS * NUM_FIELDS > (1 << IDX_W)) begin : g_bad_base
      $error("alarm registers exceed address space");
   end
   if (STATUS_IDX >= ALM_BASE && STATUS_IDX < ALM_BASE + NUM_ALARMS * NUM_FIELDS) begin : g_bad_stat
      $error("status address overlaps alarm registers");
   end
   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("PULSE_TICKS must be positive");
   end

   logic                              acc_write;
   logic [IDX_W-1:0]                  acc_index;
   logic [NUM_FIELDS-1:0][DATA_W-2:0] now_time;
   logic [NUM_ALARMS-1:0]             flag;
   logic [DATA_W-1:0]                 rd_vals [NUM_ALARMS];

   assign acc_write = acc_addr[ADDR_W-1];
   assign acc_index = acc_addr[IDX_W-1:0];

   assign now_time[FLD_SEC]  = cur_sec;
   assign now_time[FLD_MIN]  = cur_min;
   assign now_time[FLD_HOUR] = cur_hour;
   assign now_time[FLD_DAY]  = cur_day;

   for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
      tod_alarm_unit #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W),
         .BASE   (ALM_BASE + g * NUM_FIELDS)
      ) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .sec_tick  (sec_tick),
         .now_time  (now_time),
         .acc_valid (acc_valid),
         .acc_write (acc_write),
         .acc_index (acc_index),
         .wr_data   (acc_wdata),
         .rd_val    (rd_vals[g]),
         .flag      (flag[g])
      );
   end

   assign status = {{(DATA_W-NUM_ALARMS){1'b0}}, flag};

   always_comb begin
      acc_rdata = '0;
      for (int k = 0; k < NUM_ALARMS; k++) begin
         acc_rdata = acc_rdata | rd_vals[k];
      end
      if (acc_valid && !acc_write && (acc_index == STATUS_V)) begin
         acc_rdata = acc_rdata | status;
      end
   end

   assign irq0_n = !(flag[0] && irq_en0);

   if (IRQ1_PULSE) begin : g_irq1_pulse
      tod_irq_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
         .clk       (clk),
         .rst_n     (rst_n),
         .flag      (flag[1]),
         .enable    (irq_en1),
         .slow_tick (slow_tick),
         .pulse     (irq1)
      );
   end else begin : g_irq1_level
      assign irq1 = flag[1] && irq_en1;
   end
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int ALM_BASE    = 7,
   parameter int PULSE_TICKS = 2048,
   parameter bit IRQ1_PULSE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              irq_en0,
   input logic              irq_en1,
   input logic              slow_tick,
   input logic [DATA_W-1:0] status,
   input logic              irq0_n,
   input logic              irq1
);
   localparam int LOW_W = ADDR_W - 1;
   localparam int HC_W  = $clog2(PULSE_TICKS + 2) + 1;

   logic [LOW_W-1:0] low;
   logic             touch0, touch1;
   logic [HC_W-1:0]  hi_cnt;

   assign low    = acc_addr[LOW_W-1:0];
   assign touch0 = acc_valid && (int'(low) >= ALM_BASE)     && (int'(low) < ALM_BASE + 4);
   assign touch1 = acc_valid && (int'(low) >= ALM_BASE + 4) && (int'(low) < ALM_BASE + 8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (!irq1) begin
         hi_cnt <= '0;
      end else if (slow_tick && (hi_cnt != '1)) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      status[DATA_W-1:2] == '0);                                    // R4
   AST_CLEAR_ALM0: assert property (@(posedge clk) disable iff (!rst_n)
      touch0 |=> !status[0]);                                       // R5
   AST_CLEAR_ALM1: assert property (@(posedge clk) disable iff (!rst_n)
      touch1 |=> !status[1]);                                       // R5
   AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(sec_tick));                        // R6
   AST_IRQ0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en0 |-> irq0_n);                                         // R7
   AST_IRQ0_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && irq_en0) |-> !irq0_n);                          // R7
   AST_IRQ1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en1 |-> !irq1);                                          // R9

   if (IRQ1_PULSE) begin : g_pulse_chk
      AST_IRQ1_START: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq1) |-> $past(status[1]));                         // R8
      AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
         irq1 |-> (int'(hi_cnt) < PULSE_TICKS));                    // R8
   end
endmodule

bind dual_tod_alarm tod_alarm_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .ALM_BASE    (ALM_BASE),
   .PULSE_TICKS (PULSE_TICKS),
   .IRQ1_PULSE  (IRQ1_PULSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .irq_en0   (irq_en0),
   .irq_en1   (irq_en1),
   .slow_tick (slow_tick),
   .status    (status),
   .irq0_n    (irq0_n),
   .irq1      (irq1)
);

// File: tb/dual_tod_alarm_bench.sv
module dual_tod_alarm_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PULSE = 2048;
   localparam int NV = 10;

   // mask bits {day,hour,min,sec}; alarm 0 holds day 3, 08:15:30
   localparam logic [3:0]  VMASK [NV] = '{4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b1100,
                                          4'b1100, 4'b1110, 4'b1110, 4'b1111, 4'b0000};
   localparam logic [31:0] VTIME [NV] = '{32'h03081530, 32'h04081530, 32'h05081530, 32'h03091530,
                                          32'h06111530, 32'h03081630, 32'h02222230, 32'h03081531,
                                          32'h07235959, 32'h03081531};
   localparam logic        VEXP  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
   logic       acc_valid = 1'b0;
   logic [7:0] acc_addr = '0, acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       irq_en0 = 1'b0, irq_en1 = 1'b0, slow_tick = 1'b0;
   logic [7:0] status;
   logic       irq0_n, irq1;

   int errors = 0;
   int checks = 0;
   logic [7:0] last_rd;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_tod_alarm u_dual_tod_alarm (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_en0(irq_en0), .irq_en1(irq_en1), .slow_tick(slow_tick),
      .status(status), .irq0_n(irq0_n), .irq1(irq1)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_wdata = d;
      #1 last_rd = acc_rdata;
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      #1;
   endtask

   task automatic set_time(input logic [31:0] t);
      cur_day = t[30:24]; cur_hour = t[22:16]; cur_min = t[14:8]; cur_sec = t[6:0];
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 status", status, 8'h00);
      check("R1 irq0_n", irq0_n, 1'b1);
      check("R1 irq1", irq1, 1'b0);
      access(8'h07, 8'h00);
      check("R1 alarm0 sec reg", last_rd, 8'h00);

      // table of mask patterns (R2, R3)
      for (int i = 0; i < NV; i++) begin
         access(8'h87, {VMASK[i][0], 7'h30});
         access(8'h88, {VMASK[i][1], 7'h15});
         access(8'h89, {VMASK[i][2], 7'h08});
         access(8'h8A, {VMASK[i][3], 7'h03});
         set_time(VTIME[i]);
         tick();
         check(VMASK[i] == 4'b0000 ? "R2 full match" : "R3 masked match",
               status[0], VEXP[i]);
      end

      // R4 map and readback
      access(8'h8B, 8'h45);
      access(8'h8E, 8'h86);
      access(8'h0B, 8'h00);
      check("R4 read alarm1 sec", last_rd, 8'h45);
      access(8'h0E, 8'h00);
      check("R4 read alarm1 day", last_rd, 8'h86);
      access(8'h05, 8'h00);
      check("R4 unmapped read", last_rd, 8'h00);
      access(8'h09, 8'h00);
      check("R4 read alarm0 hour", last_rd, 8'h08);

      // R6 no set without tick, then sticky
      access(8'h87, 8'h30);
      access(8'h8A, 8'h03);
      set_time(32'h03081530);
      repeat (3) @(negedge clk);
      #1 check("R6 no set without tick", status[0], 1'b0);
      tick();
      check("R6 set on tick", status[0], 1'b1);
      set_time(32'h01000000);
      repeat (4) @(negedge clk);
      #1 check("R6 flag sticky", status[0], 1'b1);

      // R7 level output
      irq_en0 = 1'b1;
      #1 check("R7 irq0_n asserted", irq0_n, 1'b0);
      irq_en0 = 1'b0;
      #1 check("R7 irq0_n off when disabled", irq0_n, 1'b1);

      // R5 / R4 clear scope, status read, status write ignored
      access(8'h0C, 8'h00);
      check("R5 other alarm access keeps flag0", status[0], 1'b1);
      access(8'h10, 8'h00);
      check("R4 status read", last_rd, 8'h01);
      access(8'h90, 8'hFF);
      check("R4 status write ignored", status, 8'h01);
      access(8'h09, 8'h00);
      check("R5 read clears flag0", status[0], 1'b0);

      // R5 clear wins over same-cycle matching tick
      set_time(32'h03081530);
      tick();
      check("R5 re-set before write clear", status[0], 1'b1);
      access(8'h87, 8'h30);
      check("R5 write clears flag0", status[0], 1'b0);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 8'h07; sec_tick = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; sec_tick = 1'b0;
      #1 check("R5 clear beats tick", status[0], 1'b0);

      // R8 pulse length
      access(8'h8B, 8'h80);
      access(8'h8C, 8'h80);
      access(8'h8D, 8'h80);
      access(8'h8E, 8'h80);
      irq_en1 = 1'b1;
      slow_tick = 1'b1;
      tick();
      check("R8 flag1 set", status[1], 1'b1);
      check("R8 pulse one cycle after flag", irq1, 1'b0);
      @(negedge clk); #1;
      cnt = 0;
      while (irq1 && cnt < 5000) begin
         cnt++;
         @(negedge clk); #1;
      end
      check("R8 pulse length", cnt, PULSE);
      tick();
      check("R8 no retrigger while set", irq1, 1'b0);
      @(negedge clk); #1;
      check("R8 no retrigger next cycle", irq1, 1'b0);

      // R8 hold with idle slow_tick, R9 cancel
      access(8'h0B, 8'h00);
      slow_tick = 1'b0;
      tick();
      repeat (20) @(negedge clk);
      #1 check("R8 pulse holds without slow strobes", irq1, 1'b1);
      irq_en1 = 1'b0;
      #1 check("R9 disable forces low", irq1, 1'b0);
      @(negedge clk);
      irq_en1 = 1'b1;
      @(negedge clk); #1;
      check("R9 cancelled pulse not resumed", irq1, 1'b0);

      // R9 flag set while disabled
      irq_en1 = 1'b0;
      access(8'h0B, 8'h00);
      tick();
      check("R9 low while disabled", irq1, 1'b0);
      @(negedge clk);
      irq_en1 = 1'b1;
      @(negedge clk); #1;
      check("R9 no late pulse", irq1, 1'b0);
      check("R9 flag1 still set", status[1], 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule